// File: doc/BRIEF.md
# Byte-Write Latch and Status Controller

This block is the control side of a 2K x 8 parallel nonvolatile byte memory. It runs on a system clock and sees the three active-low bus strobes (chip select, write strobe, output strobe) already synchronized to that clock. From the strobe levels it decides whether the bus is idle, reading, writing or inhibited. For a byte write it captures the address and the data at the right strobe edges. It then holds the part busy for a self-timed programming interval, and during that interval it reports status on both the data bus and an open-drain ready/busy line.

A write phase opens on the clock edge where chip select and write strobe are first seen low together while the output strobe is high. That is the edge where the later of the two falls, and the address is taken there. The phase closes on the first edge where either strobe is seen high, and the data byte is taken on that edge. The byte is stored and a busy counter starts. While the counter runs, a read of the address just written returns the inverted bit 7 on the top data line. The ready/busy output asks the wired line to be pulled low for the whole interval. A plain register array stands in for the storage cells.

Top module: `bwl_ctrl`

## Requirements
- R1: A write phase opens only on an edge where ce_n=0, we_n=0 and oe_n=1. Holding ce_n and we_n low with oe_n low stores nothing and does not assert rb_pull_low.
- R2: The address is taken from addr on the edge where the later of ce_n/we_n is first seen low. Address changes during the rest of the phase have no effect.
- R3: The stored byte is dq_in as sampled on the edge where ce_n or we_n (whichever is first) is first seen high. Earlier dq_in values in the phase have no effect.
- R4: After the closing edge, rb_pull_low is 1 for exactly BUSY_CYCLES clock cycles and then returns to 0.
- R5: While busy, a read of the address just written gives dq_out[7] equal to the inverse of the written bit 7 and dq_out[6:0]=0. After busy ends, the read returns the written byte.
- R6: While busy, a read of any other address returns that address's stored byte.
- R7: dq_oe is 1 exactly when ce_n=0, oe_n=0 and we_n=1. While dq_oe is 0, dq_out is 0.
- R8: Write strobes that arrive while busy store nothing and do not lengthen the busy interval.
- R9: If oe_n goes low while a write phase is open, the phase is dropped. Nothing is stored and rb_pull_low stays 0.
- R10: After reset, rb_pull_low=0, dq_oe=0 and no write phase is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, synchronized |
| we_n | input | 1 | Write strobe, active low, synchronized |
| oe_n | input | 1 | Output strobe, active low, synchronized |
| addr | input | ADDR_W (11) | Byte address |
| dq_in | input | DATA_W (8) | Data bus value seen at the pins |
| dq_out | output | DATA_W (8) | Data driven toward the pins in read mode |
| dq_oe | output | 1 | Enable for the data bus drivers |
| rb_pull_low | output | 1 | 1 = pull the shared ready/busy line low |

## Verification
A wrong phase flag or a wrong address latch shows up as a byte landing at the wrong location or at none. This is visible on the first read after the busy interval ends, so the bench writes every location and reads every one back. A busy counter that loads or steps wrongly changes the number of cycles rb_pull_low stays high, and that count is compared exactly on each write. Corrupt polling registers show up at once on a read during busy, as a wrong top bit or as a polled answer on an address other than the one just written.

// File: rtl/bwl_pkg.sv
// Shared types for the byte-write latch and status controller.
// Assumes strobes are active low and already synchronized to clk.
package bwl_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_READ    = 2'd1,
        BUS_WRITE   = 2'd2,
        BUS_INHIBIT = 2'd3
    } bus_mode_e;

    // Map the three strobe levels onto a bus mode.
    function automatic bus_mode_e decode_mode(input logic ce_n, input logic we_n, input logic oe_n);
        if (ce_n)
            return BUS_IDLE;
        else if (!we_n && oe_n)
            return BUS_WRITE;
        else if (we_n && !oe_n)
            return BUS_READ;
        else
            return BUS_INHIBIT;
    endfunction

endpackage

// File: rtl/bwl_strobe_ctrl.sv
// Strobe decoder and write-phase tracker.
// Opens a phase on the first edge where the write mode is seen (the later
// of chip select / write strobe has fallen) and latches the address there.
// Closes it on the first edge where either strobe is high, producing a
// one-cycle commit; output strobe low inside a phase drops the phase.
// Assumes: strobes synchronized; no phase may open while busy.
module bwl_strobe_ctrl
    import bwl_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output bus_mode_e         mode,
    output logic              in_phase,
    output logic [ADDR_W-1:0] addr_q,
    output logic              commit
);

    logic open_phase;

    // Current bus mode from the sampled strobe levels.
    always_comb mode = decode_mode(ce_n, we_n, oe_n);

    // Phase opens on write mode while idle; closes when write mode is left.
    always_comb begin
        open_phase = (mode == BUS_WRITE) && !in_phase && !busy;
        commit     = in_phase && oe_n && (ce_n || we_n);
    end

    // Phase flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_phase <= 1'b0;
        else if (open_phase)
            in_phase <= 1'b1;
        else if (in_phase && (mode != BUS_WRITE))
            in_phase <= 1'b0;
    end

    // Address latch, loaded only when a phase opens.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (open_phase)
            addr_q <= addr;
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_phase && $past(in_phase) |-> $stable(addr_q)); // R2

    AST_NO_PHASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_phase); // R8

endmodule

// File: rtl/bwl_busy_timer.sv
// Self-timed programming interval and polling status.
// A commit loads the down-counter and records the written address and top
// data bit; busy stays high for BUSY_CYCLES cycles. Commits cannot arrive
// while busy (the strobe controller blocks them), so the timer never restarts.
module bwl_busy_timer #(
    parameter int ADDR_W      = 11,
    parameter int BUSY_CYCLES = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_msb,
    output logic              busy,
    output logic [ADDR_W-1:0] poll_addr,
    output logic              poll_msb
);

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Busy flag and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (commit && !busy) begin
            busy <= 1'b1;
            cnt  <= CNT_LOAD;
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - CNT_W'(1);
        end
    end

    // Record what the polling read must answer for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_addr <= '0;
            poll_msb  <= 1'b0;
        end else if (commit && !busy) begin
            poll_addr <= wr_addr;
            poll_msb  <= wr_msb;
        end
    end

    AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !busy |=> busy && (cnt == CNT_LOAD)); // R4

    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (cnt != '0) |=> busy && (cnt == $past(cnt) - CNT_W'(1))); // R4

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (cnt == '0) && !commit |=> !busy); // R4

endmodule

// File: rtl/bwl_cell_array.sv
// Register array standing in for the nonvolatile cells.
// One synchronous write port, one combinational read port. Contents are not
// reset, as real cells keep their value.
module bwl_cell_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store a byte on commit.
    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    // Asynchronous read of the addressed byte.
    always_comb rd_data = cells[rd_addr];

endmodule

// File: rtl/bwl_ctrl.sv
// Top of the byte-write latch and status controller.
// Ties the strobe controller, busy timer and cell array together and forms
// the data-bus output: true data, or the polling answer (inverted top bit,
// other bits zero) for the address being programmed. Drives the open-drain
// ready/busy request and a separate data-bus enable for read mode only.
module bwl_ctrl
    import bwl_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              rb_pull_low
);

    bus_mode_e         mode;
    logic              in_phase;
    logic [ADDR_W-1:0] addr_q;
    logic              commit;
    logic              busy;
    logic [ADDR_W-1:0] poll_addr;
    logic              poll_msb;
    logic [DATA_W-1:0] rd_data;
    logic              polled;

    bwl_strobe_ctrl #(.ADDR_W(ADDR_W)) i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .busy     (busy),
        .mode     (mode),
        .in_phase (in_phase),
        .addr_q   (addr_q),
        .commit   (commit)
    );

    bwl_busy_timer #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .wr_addr   (addr_q),
        .wr_msb    (dq_in[DATA_W-1]),
        .busy      (busy),
        .poll_addr (poll_addr),
        .poll_msb  (poll_msb)
    );

    bwl_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cells (
        .clk     (clk),
        .wr_en   (commit && !busy),
        .wr_addr (addr_q),
        .wr_data (dq_in),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    // Read-mode enable and polling match.
    always_comb begin
        dq_oe  = (mode == BUS_READ);
        polled = busy && (addr == poll_addr);
    end

    // Data-bus output selection.
    always_comb begin
        if (!dq_oe)
            dq_out = '0;
        else if (polled)
            dq_out = {~poll_msb, {(DATA_W-1){1'b0}}};
        else
            dq_out = rd_data;
    end

    // Open-drain request follows the programming interval.
    always_comb rb_pull_low = busy;

    AST_ABORT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        in_phase && !oe_n |=> !rb_pull_low); // R9

    AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rb_pull_low |-> !commit); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !rb_pull_low && !in_phase); // R10

endmodule

// File: tb/test_bwl_ctrl.sv
module test_bwl_ctrl;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int BC = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          rb_pull_low;

    int checks = 0;
    int fails = 0;
    int busy_cnt = 0;
    logic [DW-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    bwl_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BC)) i_bwl_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .rb_pull_low(rb_pull_low)
    );

    // Count cycles with the busy request high.
    always @(negedge clk) if (rb_pull_low) busy_cnt <= busy_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 37 + (a >> 8) * 11 + 5);
    endfunction

    task automatic idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // Called at a negedge; returns at the negedge after the commit edge.
    task automatic write_byte(input int a, input logic [DW-1:0] d);
        addr = AW'(a); dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 4 * BC && rb_pull_low; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_at(input int a, output logic [DW-1:0] d);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        d = dq_out;
    endtask

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk(rb_pull_low == 1'b0, "R10 rb", int'(rb_pull_low), 0);
        chk(dq_oe == 1'b0, "R10 oe", int'(dq_oe), 0);

        // R4 / R3 sweep: write every location, count busy cycles
        for (int a = 0; a < DEPTH; a++) begin
            busy_cnt = 0;
            write_byte(a, pat(a));
            model[a] = pat(a);
            wait_ready();
            if (a % 128 == 0 || a == DEPTH - 1)
                chk(busy_cnt == BC, "R4 busy length", busy_cnt, BC);
        end
        idle();
        @(negedge clk);
        for (int a = 0; a < DEPTH; a++) begin
            read_at(a, rd);
            chk(rd == model[a], "R3 sweep readback", int'(rd), int'(model[a]));
            @(negedge clk);
        end
        idle();
        @(negedge clk);

        // R7: mode table (write combo 0,0,1 skipped)
        for (int i = 0; i < 8; i++) begin
            logic exp_oe;
            if (i == 1) continue;
            addr = AW'(5);
            ce_n = i[2]; we_n = i[1]; oe_n = i[0];
            #1;
            exp_oe = !i[2] && !i[0] && i[1];
            chk(dq_oe == exp_oe, "R7 dq_oe", int'(dq_oe), int'(exp_oe));
            if (exp_oe)
                chk(dq_out == model[5], "R7 read data", int'(dq_out), int'(model[5]));
            else
                chk(dq_out == '0, "R7 idle dq_out", int'(dq_out), 0);
            @(negedge clk);
        end
        idle();
        @(negedge clk);

        // R1: strobes low with oe_n low is not a write
        busy_cnt = 0;
        addr = AW'(40); dq_in = 8'h77; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_cnt == 0, "R1 no busy", busy_cnt, 0);
        read_at(40, rd);
        chk(rd == model[40], "R1 data kept", int'(rd), int'(model[40]));
        @(negedge clk); idle(); @(negedge clk);

        // R2/R3: we_n falls first at A, ce_n later at B, addr moves to C;
        // ce_n rises first, data changes before and after
        busy_cnt = 0;
        addr = AW'(100); dq_in = 8'h11; we_n = 1'b0;
        @(negedge clk);
        addr = AW'(200); ce_n = 1'b0;
        @(negedge clk);
        addr = AW'(300);
        @(negedge clk);
        dq_in = 8'hA5; ce_n = 1'b1;
        @(negedge clk);
        dq_in = 8'hFF; we_n = 1'b1;
        model[200] = 8'hA5;
        wait_ready();
        chk(busy_cnt == BC, "R4 busy length", busy_cnt, BC);
        read_at(200, rd);
        chk(rd == 8'hA5, "R2 R3 latched byte", int'(rd), 8'hA5);
        @(negedge clk);
        read_at(100, rd);
        chk(rd == model[100], "R2 first addr untouched", int'(rd), int'(model[100]));
        @(negedge clk);
        read_at(300, rd);
        chk(rd == model[300], "R2 later addr untouched", int'(rd), int'(model[300]));
        @(negedge clk); idle(); @(negedge clk);

        // R5/R6: polling with bit 7 set then clear
        for (int k = 0; k < 2; k++) begin
            logic [DW-1:0] d;
            logic [DW-1:0] pexp;
            d = (k == 0) ? 8'h80 : 8'h3C;
            pexp = (k == 0) ? 8'h00 : 8'h80;
            write_byte(500, d);
            model[500] = d;
            for (int c = 0; c < 4; c++) begin
                read_at(500, rd);
                chk(rd == pexp, "R5 polled answer", int'(rd), int'(pexp));
                @(negedge clk);
            end
            read_at(501, rd);
            chk(rd == model[501], "R6 other addr while busy", int'(rd), int'(model[501]));
            @(negedge clk);
            idle();
            wait_ready();
            read_at(500, rd);
            chk(rd == d, "R5 true data after busy", int'(rd), int'(d));
            @(negedge clk); idle(); @(negedge clk);
        end

        // R8: write attempt while busy is ignored and does not extend busy
        busy_cnt = 0;
        write_byte(600, 8'h42);
        model[600] = 8'h42;
        addr = AW'(605); dq_in = 8'h99; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        wait_ready();
        chk(busy_cnt == BC, "R8 busy not extended", busy_cnt, BC);
        read_at(605, rd);
        chk(rd == model[605], "R8 ignored write", int'(rd), int'(model[605]));
        @(negedge clk); idle(); @(negedge clk);

        // R9: oe_n low inside a phase drops it
        busy_cnt = 0;
        addr = AW'(700); dq_in = 8'h5A; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_cnt == 0, "R9 no busy", busy_cnt, 0);
        read_at(700, rd);
        chk(rd == model[700], "R9 data kept", int'(rd), int'(model[700]));
        @(negedge clk); idle(); @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule